// File: doc/BRIEF.md
# Serial Power-of-Two Coefficient FIR Filter

This block is a time-multiplexed FIR filter. It needs no hardware multiplier. Each coefficient is written as a sum of signed power-of-two terms. The block forms every product by shifting a stored sample and adding it to, or subtracting it from, one shared accumulator. A small state machine walks the term list once for every incoming sample, so the whole filter costs one adder, one shifter and two small memories.

Software or a loader first pulses `coef_start`. It then presents the term words on `coef_word`, one per system clock. Samples arrive on a slower strobe that is asynchronous to the system clock; the block synchronises it with two flops. Each accepted sample is written into a circular history memory and acknowledged on `sample_ack`. After the term walk, the scaled, floor-truncated and saturated result is loaded into an output register and `result_valid` pulses. A sample strobe that arrives while a result is still being computed is dropped, and `overrun` pulses.

Top module: `pot_serial_fir`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0 and `result_valid`, `sample_ack` and `overrun` are all 0.
- R2: Until a full term list has been loaded after reset, sample strobes are ignored: no `sample_ack`, no `result_valid`, no `overrun`.
- R3: The clock after `coef_start` is sampled high, the block takes exactly TERMS words from `coef_word`, one per clock. Each word has three fields:
  - bit 7 is the sign (1 means subtract);
  - bits 6:3 are the shift amount;
  - bits 2:0 are the tap index, where tap 0 is the newest sample.
- R4: Each rising edge of `sample_strobe` accepted while idle stores `sample_in` and pulses `sample_ack` for one clock. The result is floor((Σ ±x[n−tap]·2^shift) / 2^FRAC), where FRAC defaults to 8. History older than the samples received since reset counts as zero.
- R5: `result_valid` is a one-clock pulse exactly TERMS clocks after `sample_ack`. `result` changes only on that clock.
- R6: A scaled sum above 32767 gives 32767, and a scaled sum below −32768 gives −32768.
- R7: A negative scaled sum is truncated toward minus infinity (for example, −1/256 gives −1).
- R8: A strobe edge during the term walk pulses `overrun` for one clock, and its sample is dropped from the history. The result in progress is unaffected.
- R9: A new `coef_start` replaces the whole term list, and the sample history is kept across the reload.
- R10: The accumulator is wide enough that no partial sum ever wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_strobe | input | 1 | Data-rate strobe; a rising edge offers a sample |
| sample_in | input | 16 | Signed sample, held stable while the strobe is high |
| sample_ack | output | 1 | One-clock pulse when a sample is taken |
| coef_start | input | 1 | Starts loading a new term list |
| coef_word | input | 8 | Term word {sign, shift[3:0], tap[2:0]} |
| result | output | 16 | Signed filter output register |
| result_valid | output | 1 | One-clock pulse when `result` is updated |
| overrun | output | 1 | One-clock pulse when a sample arrives during the walk |

## Verification
On every cycle, the assertions check the following:
- the single-clock shape of the valid, acknowledge and overrun pulses;
- that the output register holds between results;
- that acknowledgement starts a walk at term 0;
- that strobes are refused before loading;
- that no accumulation step wraps its sign.

Only the bench scenarios can show the arithmetic itself. They compare against a model that rebuilds each coefficient from its terms, and they cover floor truncation, saturation at both rails, retained history across a reload, and the loss of an overrunning sample.

// File: rtl/pot_fir_pkg.sv
package pot_fir_pkg;
    typedef enum logic [1:0] {
        ST_NOCOEF = 2'd0,
        ST_LOAD   = 2'd1,
        ST_IDLE   = 2'd2,
        ST_CALC   = 2'd3
    } fir_state_e;
endpackage

// File: rtl/pot_fir_shift.sv
// Turns one sample and one signed power-of-two term into an accumulator-width addend.
module pot_fir_shift #(
    parameter int DW  = 16,
    parameter int SHW = 4,
    parameter int AW  = 40
) (
    input  logic signed [DW-1:0]  smp,
    input  logic                  neg,
    input  logic        [SHW-1:0] sh,
    output logic signed [AW-1:0]  addend
);
    logic signed [AW-1:0] ext;
    logic signed [AW-1:0] shifted;

    always_comb begin
        ext     = {{(AW-DW){smp[DW-1]}}, smp};
        shifted = ext <<< sh;
        addend  = neg ? -shifted : shifted;
    end
endmodule

// File: rtl/pot_fir_sat.sv
// Scales the accumulator down by FRAC bits (floor) and clamps it to the output range.
module pot_fir_sat #(
    parameter int AW   = 40,
    parameter int OW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [AW-1:0] acc,
    output logic        [OW-1:0] y
);
    localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [AW-1:0] scaled;

    always_comb begin
        scaled = acc >>> FRAC;
        if (scaled > MAXV)      y = MAXV[OW-1:0];
        else if (scaled < MINV) y = MINV[OW-1:0];
        else                    y = scaled[OW-1:0];
    end
endmodule

// File: rtl/pot_fir_hist.sv
// Circular sample history: one write port, one combinational read port.
module pot_fir_hist #(
    parameter int DW   = 16,
    parameter int TAPS = 8,
    localparam int TAPW = $clog2(TAPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic        [TAPW-1:0] waddr,
    input  logic signed [DW-1:0]   wdata,
    input  logic        [TAPW-1:0] raddr,
    output logic signed [DW-1:0]   rdata
);
    logic signed [DW-1:0] mem_d [TAPS];
    logic signed [DW-1:0] mem_q [TAPS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
        rdata = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/pot_serial_fir.sv
module pot_serial_fir
    import pot_fir_pkg::*;
#(
    parameter int DW    = 16,
    parameter int OW    = 16,
    parameter int TAPS  = 8,
    parameter int TERMS = 16,
    parameter int SHW   = 4,
    parameter int FRAC  = 8,
    localparam int TAPW = $clog2(TAPS),
    localparam int TW   = 1 + SHW + TAPW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_strobe,
    input  logic signed [DW-1:0] sample_in,
    output logic                 sample_ack,
    input  logic                 coef_start,
    input  logic [TW-1:0]        coef_word,
    output logic [OW-1:0]        result,
    output logic                 result_valid,
    output logic                 overrun
);
    localparam int CW = $clog2(TERMS);
    // data width + largest shift + growth over TERMS additions + guard bit
    localparam int AW = DW + (1 << SHW) + CW + 1;

    typedef struct packed {
        fir_state_e      st;
        logic [CW-1:0]   idx;
        logic [TAPW-1:0] wp;
        logic [AW-1:0]   acc;
        logic [OW-1:0]   res;
        logic            vld;
        logic            ack;
        logic            ovr;
        logic [2:0]      sync;
    } ctl_t;

    ctl_t q, d;
    logic [TW-1:0] terms_d [TERMS];
    logic [TW-1:0] terms_q [TERMS];

    logic                 strobe_edge;
    logic [TW-1:0]        cur;
    logic [TAPW-1:0]      rd_addr;
    logic signed [DW-1:0] rd_data;
    logic signed [AW-1:0] addend;
    logic signed [AW-1:0] acc_sum;
    logic [OW-1:0]        sat_y;
    logic                 hist_we;
    logic                 last_term;

    assign cur     = terms_q[q.idx];
    assign rd_addr = q.wp - cur[TAPW-1:0];

    pot_fir_hist #(.DW(DW), .TAPS(TAPS)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hist_we),
        .waddr (q.wp + 1'b1),
        .wdata (sample_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    pot_fir_shift #(.DW(DW), .SHW(SHW), .AW(AW)) u_shift (
        .smp    (rd_data),
        .neg    (cur[TW-1]),
        .sh     (cur[TW-2 -: SHW]),
        .addend (addend)
    );

    assign acc_sum = $signed(q.acc) + addend;

    pot_fir_sat #(.AW(AW), .OW(OW), .FRAC(FRAC)) u_sat (
        .acc (acc_sum),
        .y   (sat_y)
    );

    always_comb begin
        d           = q;
        d.vld       = 1'b0;
        d.ack       = 1'b0;
        d.ovr       = 1'b0;
        d.sync      = {q.sync[1:0], sample_strobe};
        strobe_edge = q.sync[1] & ~q.sync[2];
        last_term   = (q.idx == CW'(TERMS - 1));
        terms_d     = terms_q;
        hist_we     = 1'b0;
        if (coef_start) begin
            d.st  = ST_LOAD;
            d.idx = '0;
        end else begin
            case (q.st)
                ST_LOAD: begin
                    terms_d[q.idx] = coef_word;
                    d.idx = q.idx + 1'b1;
                    if (last_term) begin
                        d.st  = ST_IDLE;
                        d.idx = '0;
                    end
                end
                ST_IDLE: begin
                    if (strobe_edge) begin
                        hist_we = 1'b1;
                        d.wp    = q.wp + 1'b1;
                        d.acc   = '0;
                        d.idx   = '0;
                        d.ack   = 1'b1;
                        d.st    = ST_CALC;
                    end
                end
                ST_CALC: begin
                    d.acc = acc_sum;
                    d.idx = q.idx + 1'b1;
                    d.ovr = strobe_edge;
                    if (last_term) begin
                        d.st  = ST_IDLE;
                        d.idx = '0;
                        d.res = sat_y;
                        d.vld = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < TERMS; i++) terms_q[i] <= '0;
        end else begin
            q       <= d;
            terms_q <= terms_d;
        end
    end

    assign result       = q.res;
    assign result_valid = q.vld;
    assign sample_ack   = q.ack;
    assign overrun      = q.ovr;

    assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    assert_res_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));
    assert_ack_starts_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ack |-> (q.st == ST_CALC && q.idx == '0 && q.acc == '0));
    assert_ovr_in_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(q.st == ST_CALC));
    assert_no_early_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NOCOEF || q.st == ST_LOAD) |-> !sample_ack && !result_valid);
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CALC && !coef_start && q.acc[AW-1] == addend[AW-1])
            |-> acc_sum[AW-1] == q.acc[AW-1]);
endmodule

// File: tb/tb_pot_serial_fir.sv
module tb_pot_serial_fir;
    localparam int TAPS  = 8;
    localparam int TERMS = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_strobe = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic              sample_ack;
    logic              coef_start = 1'b0;
    logic [7:0]        coef_word = '0;
    logic [15:0]       result;
    logic              result_valid;
    logic              overrun;

    int checks = 0;
    int fails  = 0;

    logic [7:0] tw [TERMS];
    longint     hm [TAPS];

    always #5 clk = ~clk;

    pot_serial_fir dut (
        .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .sample_in(sample_in),
        .sample_ack(sample_ack), .coef_start(coef_start), .coef_word(coef_word),
        .result(result), .result_valid(result_valid), .overrun(overrun)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit sg, input int sh, input int tap);
        return {sg, 4'(sh), 3'(tap)};
    endfunction

    function automatic longint model_y();
        longint sum = 0;
        longint y;
        for (int i = 0; i < TERMS; i++) begin
            longint v;
            v = hm[tw[i][2:0]] * (longint'(1) << tw[i][6:3]);
            sum += tw[i][7] ? -v : v;
        end
        y = sum >>> 8;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        return y;
    endfunction

    // fill terms from index k upward with cancelling pairs on tap 5
    task automatic pad_from(input int k);
        for (int i = k; i < TERMS; i += 2) begin
            tw[i]   = mk(0, i % 16, 5);
            tw[i+1] = mk(1, i % 16, 5);
        end
    endtask

    task automatic drive_coefs();
        coef_start = 1'b1;
        @(negedge clk);
        coef_start = 1'b0;
        for (int i = 0; i < TERMS; i++) begin
            coef_word = tw[i];
            @(negedge clk);
        end
        coef_word = '0;
        @(negedge clk);
    endtask

    task automatic set_a();
        tw[0] = mk(0,8,0);  tw[1] = mk(0,7,1);  tw[2] = mk(1,5,1);  tw[3] = mk(1,6,2);
        tw[4] = mk(0,4,3);  tw[5] = mk(0,3,3);  tw[6] = mk(0,0,3);  tw[7] = mk(1,9,4);
        tw[8] = mk(0,2,4);  tw[9] = mk(0,5,5);  tw[10] = mk(1,1,6); tw[11] = mk(0,3,7);
        tw[12] = mk(0,10,7); tw[13] = mk(1,10,7); tw[14] = mk(0,0,5); tw[15] = mk(1,12,6);
    endtask

    // Offer one sample; returns the result and checks ack/valid timing (R4, R5).
    task automatic send_sample(input logic signed [15:0] v, output longint y);
        int ack_at = -1;
        int vld_at = -1;
        int ovr_n  = 0;
        y = 0;
        sample_in = v;
        sample_strobe = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (c == 3) sample_strobe = 1'b0;
            if (sample_ack) ack_at = c;
            if (overrun) ovr_n++;
            if (result_valid && vld_at < 0) begin
                vld_at = c;
                y = longint'($signed(result));
            end
        end
        for (int i = TAPS - 1; i > 0; i--) hm[i] = hm[i-1];
        hm[0] = v;
        chk("R4 sample_ack seen", longint'(ack_at >= 0), 1);
        chk("R5 valid latency after ack", longint'(vld_at - ack_at), TERMS);
        chk("R8 no overrun on spaced sample", ovr_n, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 result during reset", result, 0);
        chk("R1 valid during reset", result_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 result after reset", result, 0);
        chk("R1 ack/valid/overrun after reset", {sample_ack, result_valid, overrun}, 0);
    endtask

    task automatic t_nocoef();
        int seen = 0;
        sample_in = 16'sd1000;
        sample_strobe = 1'b1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (c == 4) sample_strobe = 1'b0;
            if (sample_ack || result_valid || overrun) seen++;
        end
        chk("R2 strobe ignored before load", seen, 0);
    endtask

    task automatic t_impulse();
        longint y;
        set_a();
        drive_coefs();
        send_sample(16'sd256, y);
        chk("R3 impulse tap0", y, 256);
        chk("R4 impulse tap0 model", y, model_y());
        for (int k = 1; k < TAPS + 1; k++) begin
            send_sample(16'sd0, y);
            chk("R4 impulse response", y, model_y());
        end
    endtask

    task automatic t_random();
        longint y;
        for (int k = 0; k < 20; k++) begin
            send_sample(16'($urandom_range(0, 65535)), y);
            chk("R4 random sample vs model", y, model_y());
        end
    endtask

    task automatic t_floor();
        longint y;
        tw[0] = mk(0,1,0);
        tw[1] = mk(1,0,0);
        pad_from(2);
        drive_coefs();
        send_sample(-16'sd1, y);
        chk("R7 floor of -1/256", y, -1);
        send_sample(16'sd255, y);
        chk("R7 255/256 truncates to 0", y, 0);
        send_sample(-16'sd257, y);
        chk("R7 floor of -257/256", y, -2);
    endtask

    task automatic t_sat();
        longint y;
        tw[0] = mk(0,11,0);
        tw[1] = mk(0,11,0);
        pad_from(2);
        drive_coefs();
        send_sample(16'sd4096, y);
        chk("R6 positive saturation", y, 32767);
        send_sample(-16'sd4096, y);
        chk("R6 negative saturation", y, -32768);
        send_sample(16'sd2047, y);
        chk("R6 just inside range", y, 32752);
        send_sample(-16'sd2049, y);
        chk("R6 just below range", y, -32768);
    endtask

    task automatic t_reload_overrun();
        longint y;
        int ovr_n = 0;
        int vld_n = 0;
        set_a();
        drive_coefs();
        send_sample(16'sd300, y);
        chk("R9 reload keeps history", y, model_y());
        sample_in = 16'sd1234;
        sample_strobe = 1'b1;
        y = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (c == 3) sample_strobe = 1'b0;
            if (c == 6) begin
                sample_in = 16'sd9999;
                sample_strobe = 1'b1;
            end
            if (c == 9) sample_strobe = 1'b0;
            if (overrun) ovr_n++;
            if (result_valid) begin
                vld_n++;
                y = longint'($signed(result));
            end
        end
        for (int i = TAPS - 1; i > 0; i--) hm[i] = hm[i-1];
        hm[0] = 1234;
        chk("R8 one overrun pulse", ovr_n, 1);
        chk("R8 single result", vld_n, 1);
        chk("R8 result unaffected", y, model_y());
        send_sample(-16'sd77, y);
        chk("R8 dropped sample absent from history", y, model_y());
    endtask

    initial begin
        for (int i = 0; i < TAPS; i++) hm[i] = 0;
        t_reset();
        t_nocoef();
        t_impulse();
        t_random();
        t_floor();
        t_sat();
        t_reload_overrun();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule